// File: doc/BRIEF.md
# Indirect Management Register Access Sequencer

This block sits on the host side of a management bus. It takes a request to read or write one register of a device inside a switch and turns it into the single direct bus transactions that reach that register. When the switch is strapped to address zero, the switch answers at every bus address. In that case each request maps onto one direct transaction at bus address equal to the device number.

When the switch sits at a non-zero address, it exposes only a command register at offset 0 and a data register at offset 1. The block then polls the command register until its busy flag clears, and it gives up after a bounded number of polls. Reads and writes use different orders of transactions. A part that cannot work behind a non-zero address is refused with a configuration error, and no bus traffic is issued for it.

The upstream side accepts one request at a time and answers with a one-cycle response carrying a result code and read data. The downstream side issues one transaction at a time through a valid/ready handshake, then waits for a response strobe that carries read data and an error flag. The serial engine that carries these transactions on the wire is outside the block.

Top module: `mgmt_indirect_seq`

## Requirements
- R1: With `cfg_sw_addr` equal to 0 (direct mode), a request produces exactly one downstream transaction at `mg_phy` = device number and `mg_reg` = register number, with the request's write flag and write data. There is no polling, and for a read the response returns that transaction's read data.
- R2: With `cfg_sw_addr` non-zero and `cfg_multi_ok` high (indirect mode), every downstream transaction targets `mg_phy` = `cfg_sw_addr`.
- R3: With `cfg_sw_addr` non-zero and `cfg_multi_ok` low, a request is answered with result code 3 (bad configuration) and no downstream transaction is issued.
- R4: In indirect mode, a command is issued only after a read of register 0 returns bit 15 = 0. Register 0 is read repeatedly while bit 15 is 1, and the other bits of the returned value are ignored.
- R5: Each busy wait allows at most 16 reads of register 0. If the 16th read still shows bit 15 = 1, the request ends with result code 2 (timeout) and issues nothing further. A 16th read showing 0 lets the sequence continue.
- R6: An indirect read runs: busy wait, write of the command to register 0, busy wait, read of register 1. The read of register 1 is returned as the response data.
- R7: An indirect write runs: busy wait, write of the request data to register 1, write of the command to register 0, busy wait. It then responds with result code 0.
- R8: The command word has bit 15 = 1, bit 12 = 1, bits 11:10 = 2'b10 for a read or 2'b01 for a write, bits 9:5 = device number, and bits 4:0 = register number.
- R9: A downstream response with `mg_rsp_err` high ends the request at once with result code 1 (bus error). No further downstream transaction is issued for that request.
- R10: `req_ready` is high only when the block is idle. It drops on the cycle after a request is accepted and stays low until the response has been given.
- R11: `mg_valid`, `mg_write`, `mg_phy`, `mg_reg` and `mg_wdata` stay stable while `mg_valid` waits for `mg_ready`. After a handshake, `mg_valid` stays low until the response arrives.
- R12: `rsp_valid` is a one-cycle pulse for each request. `rsp_rdata` is 0 unless the request was a read that completed with result code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_sw_addr | input | 5 | Bus address of the switch; 0 selects direct mode |
| cfg_multi_ok | input | 1 | Part supports operation at a non-zero address |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dev | input | 5 | Internal device number |
| req_reg | input | 5 | Internal register number |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_result | output | 2 | 0 ok, 1 bus error, 2 timeout, 3 bad configuration |
| rsp_rdata | output | 16 | Read data |
| mg_valid | output | 1 | Downstream transaction request |
| mg_ready | input | 1 | Downstream transaction accepted |
| mg_write | output | 1 | Downstream transaction is a write |
| mg_phy | output | 5 | Downstream bus address |
| mg_reg | output | 5 | Downstream register |
| mg_wdata | output | 16 | Downstream write data |
| mg_rsp_valid | input | 1 | Downstream response strobe |
| mg_rsp_err | input | 1 | Downstream transaction failed |
| mg_rsp_rdata | input | 16 | Downstream read data |

## Verification
A wrong step or a wrong poll count becomes visible on the downstream port at the next transaction. That transaction then carries the wrong register, write flag, data or address, so the bench compares every downstream transaction against its own expected list as it happens. An off-by-one in the busy-wait bound shows only at the 15- and 16-busy boundaries. Those cases show up one transaction late, as an extra poll or a missing one, and then as a wrong result code. A stuck state shows as `req_ready` staying low, or as a response that never arrives, within the length of one request.

// File: rtl/mgmt_seq_pkg.sv
package mgmt_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_RESP
    } seq_state_e;

    typedef enum logic [2:0] {
        STEP_DIRECT,
        STEP_POLL_PRE,
        STEP_CMD,
        STEP_POLL_POST,
        STEP_DATA_WR,
        STEP_DATA_RD
    } seq_step_e;

    localparam logic [1:0] RESULT_OK      = 2'd0;
    localparam logic [1:0] RESULT_BUS     = 2'd1;
    localparam logic [1:0] RESULT_TIMEOUT = 2'd2;
    localparam logic [1:0] RESULT_BADCFG  = 2'd3;

    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_WRITE = 2'b01;

endpackage

// File: rtl/mgmt_poll_ctr.sv
module mgmt_poll_ctr #(
    parameter int POLL_MAX = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int CNT_W = (POLL_MAX > 1) ? $clog2(POLL_MAX) : 1;
    localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(POLL_MAX - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last = (cnt_q == LAST_VAL);

endmodule

// File: rtl/mgmt_cmd_word.sv
module mgmt_cmd_word #(
    parameter int ADDR_W   = 5,
    parameter int REG_W    = 5,
    parameter int DATA_W   = 16,
    parameter int BUSY_BIT = 15,
    parameter int MODE_BIT = 12,
    parameter int OP_LSB   = 10
) (
    input  logic              is_write,
    input  logic [ADDR_W-1:0] dev,
    input  logic [REG_W-1:0]  rg,
    output logic [DATA_W-1:0] word
);
    import mgmt_seq_pkg::*;

    always_comb begin
        word                 = '0;
        word[BUSY_BIT]       = 1'b1;
        word[MODE_BIT]       = 1'b1;
        word[OP_LSB +: 2]    = is_write ? OPC_WRITE : OPC_READ;
        word[REG_W +: ADDR_W] = dev;
        word[REG_W-1:0]      = rg;
    end

endmodule

// File: rtl/mgmt_indirect_seq.sv
module mgmt_indirect_seq #(
    parameter int ADDR_W   = 5,
    parameter int REG_W    = 5,
    parameter int DATA_W   = 16,
    parameter int POLL_MAX = 16,
    parameter int BUSY_BIT = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_sw_addr,
    input  logic              cfg_multi_ok,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_dev,
    input  logic [REG_W-1:0]  req_reg,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [1:0]        rsp_result,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mg_valid,
    input  logic              mg_ready,
    output logic              mg_write,
    output logic [ADDR_W-1:0] mg_phy,
    output logic [REG_W-1:0]  mg_reg,
    output logic [DATA_W-1:0] mg_wdata,
    input  logic              mg_rsp_valid,
    input  logic              mg_rsp_err,
    input  logic [DATA_W-1:0] mg_rsp_rdata
);
    import mgmt_seq_pkg::*;

    localparam logic [REG_W-1:0] CMD_OFS  = REG_W'(0);
    localparam logic [REG_W-1:0] DATA_OFS = REG_W'(1);

    typedef struct packed {
        seq_state_e        st;
        seq_step_e         step;
        logic              is_wr;
        logic [ADDR_W-1:0] dev;
        logic [REG_W-1:0]  rg;
        logic [DATA_W-1:0] wd;
        logic [1:0]        result;
        logic [DATA_W-1:0] rdata;
    } seq_t;

    localparam seq_t SEQ_RESET = '{
        st:     ST_IDLE,
        step:   STEP_DIRECT,
        is_wr:  1'b0,
        dev:    '0,
        rg:     '0,
        wd:     '0,
        result: RESULT_OK,
        rdata:  '0
    };

    seq_t s_d, s_q;
    logic poll_clr, poll_inc, poll_last;
    logic [DATA_W-1:0] cmd_word;
    logic direct_sel;

    mgmt_poll_ctr #(
        .POLL_MAX (POLL_MAX)
    ) poll_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (poll_clr),
        .inc   (poll_inc),
        .last  (poll_last)
    );

    mgmt_cmd_word #(
        .ADDR_W   (ADDR_W),
        .REG_W    (REG_W),
        .DATA_W   (DATA_W),
        .BUSY_BIT (BUSY_BIT)
    ) cmd_i (
        .is_write (s_q.is_wr),
        .dev      (s_q.dev),
        .rg       (s_q.rg),
        .word     (cmd_word)
    );

    assign direct_sel = (cfg_sw_addr == '0);

    // next-state computation
    always_comb begin
        s_d      = s_q;
        poll_clr = 1'b0;
        poll_inc = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    poll_clr   = 1'b1;
                    s_d.is_wr  = req_write;
                    s_d.dev    = req_dev;
                    s_d.rg     = req_reg;
                    s_d.wd     = req_wdata;
                    s_d.rdata  = '0;
                    s_d.result = RESULT_OK;
                    if (direct_sel) begin
                        s_d.step = STEP_DIRECT;
                        s_d.st   = ST_ISSUE;
                    end else if (!cfg_multi_ok) begin
                        s_d.result = RESULT_BADCFG;
                        s_d.st     = ST_RESP;
                    end else begin
                        s_d.step = STEP_POLL_PRE;
                        s_d.st   = ST_ISSUE;
                    end
                end
            end
            ST_ISSUE: begin
                if (mg_ready) begin
                    s_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (mg_rsp_valid) begin
                    if (mg_rsp_err) begin
                        s_d.result = RESULT_BUS;
                        s_d.st     = ST_RESP;
                    end else begin
                        unique case (s_q.step)
                            STEP_DIRECT: begin
                                if (!s_q.is_wr) begin
                                    s_d.rdata = mg_rsp_rdata;
                                end
                                s_d.st = ST_RESP;
                            end
                            STEP_POLL_PRE, STEP_POLL_POST: begin
                                if (!mg_rsp_rdata[BUSY_BIT]) begin
                                    poll_clr = 1'b1;
                                    s_d.st   = ST_ISSUE;
                                    if (s_q.step == STEP_POLL_PRE) begin
                                        s_d.step = s_q.is_wr ? STEP_DATA_WR : STEP_CMD;
                                    end else if (s_q.is_wr) begin
                                        s_d.st = ST_RESP;
                                    end else begin
                                        s_d.step = STEP_DATA_RD;
                                    end
                                end else if (poll_last) begin
                                    s_d.result = RESULT_TIMEOUT;
                                    s_d.st     = ST_RESP;
                                end else begin
                                    poll_inc = 1'b1;
                                    s_d.st   = ST_ISSUE;
                                end
                            end
                            STEP_DATA_WR: begin
                                s_d.step = STEP_CMD;
                                s_d.st   = ST_ISSUE;
                            end
                            STEP_CMD: begin
                                s_d.step = STEP_POLL_POST;
                                s_d.st   = ST_ISSUE;
                            end
                            STEP_DATA_RD: begin
                                s_d.rdata = mg_rsp_rdata;
                                s_d.st    = ST_RESP;
                            end
                            default: s_d.st = ST_RESP;
                        endcase
                    end
                end
            end
            ST_RESP: begin
                s_d.st = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= SEQ_RESET;
        end else begin
            s_q <= s_d;
        end
    end

    // downstream transaction fields from the current step
    always_comb begin
        mg_write = 1'b0;
        mg_phy   = cfg_sw_addr;
        mg_reg   = CMD_OFS;
        mg_wdata = '0;
        unique case (s_q.step)
            STEP_DIRECT: begin
                mg_write = s_q.is_wr;
                mg_phy   = s_q.dev;
                mg_reg   = s_q.rg;
                mg_wdata = s_q.wd;
            end
            STEP_CMD: begin
                mg_write = 1'b1;
                mg_wdata = cmd_word;
            end
            STEP_DATA_WR: begin
                mg_write = 1'b1;
                mg_reg   = DATA_OFS;
                mg_wdata = s_q.wd;
            end
            STEP_DATA_RD: begin
                mg_reg = DATA_OFS;
            end
            default: ;
        endcase
    end

    assign mg_valid   = (s_q.st == ST_ISSUE);
    assign req_ready  = (s_q.st == ST_IDLE);
    assign rsp_valid  = (s_q.st == ST_RESP);
    assign rsp_result = s_q.result;
    assign rsp_rdata  = s_q.rdata;

endmodule

// File: rtl/mgmt_indirect_seq_chk.sv
module mgmt_indirect_seq_chk #(
    parameter int ADDR_W = 5,
    parameter int REG_W  = 5,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] cfg_sw_addr,
    input logic              cfg_multi_ok,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [1:0]        rsp_result,
    input logic              mg_valid,
    input logic              mg_ready,
    input logic              mg_write,
    input logic [ADDR_W-1:0] mg_phy,
    input logic [REG_W-1:0]  mg_reg,
    input logic [DATA_W-1:0] mg_wdata,
    input logic              mg_rsp_valid,
    input logic              mg_rsp_err
);

    p_ready_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_rsp_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mg_valid && !mg_ready) |=> (mg_valid && $stable(mg_write) && $stable(mg_phy)
                                     && $stable(mg_reg) && $stable(mg_wdata)));

    p_one_out_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mg_valid && mg_ready) |=> !mg_valid);

    p_sw_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mg_valid && cfg_sw_addr != '0) |-> (mg_phy == cfg_sw_addr));

    p_badcfg_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && cfg_sw_addr != '0 && !cfg_multi_ok)
            |=> (rsp_valid && rsp_result == 2'd3 && !mg_valid));

    p_bus_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mg_rsp_valid && mg_rsp_err && !req_ready && !rsp_valid)
            |=> (rsp_valid && rsp_result == 2'd1 && !mg_valid));

    p_cmd_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mg_valid && mg_write && cfg_sw_addr != '0 && mg_reg == '0)
            |-> (mg_wdata[15] && mg_wdata[12]
                 && (mg_wdata[11:10] == 2'b01 || mg_wdata[11:10] == 2'b10)));

endmodule

bind mgmt_indirect_seq mgmt_indirect_seq_chk #(
    .ADDR_W (ADDR_W),
    .REG_W  (REG_W),
    .DATA_W (DATA_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_sw_addr  (cfg_sw_addr),
    .cfg_multi_ok (cfg_multi_ok),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .rsp_valid    (rsp_valid),
    .rsp_result   (rsp_result),
    .mg_valid     (mg_valid),
    .mg_ready     (mg_ready),
    .mg_write     (mg_write),
    .mg_phy       (mg_phy),
    .mg_reg       (mg_reg),
    .mg_wdata     (mg_wdata),
    .mg_rsp_valid (mg_rsp_valid),
    .mg_rsp_err   (mg_rsp_err)
);

// File: tb/mgmt_indirect_seq_tb_top.sv
module mgmt_indirect_seq_tb_top;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n;
    logic [4:0]  cfg_sw_addr;
    logic        cfg_multi_ok;
    logic        req_valid, req_ready, req_write;
    logic [4:0]  req_dev, req_reg;
    logic [15:0] req_wdata;
    logic        rsp_valid;
    logic [1:0]  rsp_result;
    logic [15:0] rsp_rdata;
    logic        mg_valid, mg_ready, mg_write;
    logic [4:0]  mg_phy, mg_reg;
    logic [15:0] mg_wdata;
    logic        mg_rsp_valid, mg_rsp_err;
    logic [15:0] mg_rsp_rdata;

    mgmt_indirect_seq dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_sw_addr(cfg_sw_addr), .cfg_multi_ok(cfg_multi_ok),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_dev(req_dev), .req_reg(req_reg), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_result(rsp_result), .rsp_rdata(rsp_rdata),
        .mg_valid(mg_valid), .mg_ready(mg_ready), .mg_write(mg_write),
        .mg_phy(mg_phy), .mg_reg(mg_reg), .mg_wdata(mg_wdata),
        .mg_rsp_valid(mg_rsp_valid), .mg_rsp_err(mg_rsp_err), .mg_rsp_rdata(mg_rsp_rdata)
    );

    typedef struct {
        bit          w;
        logic [4:0]  phy;
        logic [4:0]  rg;
        logic [15:0] wd;
        string       tag;
    } xact_t;

    typedef struct {
        logic [1:0]  res;
        logic [15:0] rd;
        string       tag;
    } resp_t;

    xact_t xq[$];
    resp_t rq[$];
    int n_chk = 0;
    int n_err = 0;

    // target model state
    int          busy_left, post_m, err_at, xidx, stall_n, stall_left;
    bit          cur_direct;
    logic [15:0] tgt_data;
    bit          cap_w;
    logic [4:0]  cap_phy, cap_rg;
    logic [15:0] cap_wd;

    // expectation builder state
    int    e_idx, e_errat;
    bit    e_dead;
    logic [1:0] e_res;
    string e_tag;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic respond();
        xact_t x;
        if (xq.size() == 0) begin
            chk(1'b0, "R9", "unexpected downstream transaction reg", 32'(cap_rg), 32'hffff);
        end else begin
            x = xq.pop_front();
            chk(cap_w == x.w, x.tag, "txn write flag", 32'(cap_w), 32'(x.w));
            chk(cap_phy == x.phy, x.tag, "txn address", 32'(cap_phy), 32'(x.phy));
            chk(cap_rg == x.rg, x.tag, "txn register", 32'(cap_rg), 32'(x.rg));
            if (x.w) chk(cap_wd == x.wd, x.tag, "txn write data", 32'(cap_wd), 32'(x.wd));
        end
        mg_rsp_rdata = 16'h0000;
        mg_rsp_err   = 1'b0;
        if (xidx == err_at) begin
            mg_rsp_err   = 1'b1;
            mg_rsp_rdata = 16'hdead;
        end else if (cur_direct) begin
            mg_rsp_rdata = cap_w ? 16'h0000 : tgt_data;
        end else if (!cap_w && cap_rg == 5'd0) begin
            if (busy_left > 0) begin
                busy_left--;
                mg_rsp_rdata = 16'h8abc;
            end else begin
                mg_rsp_rdata = 16'h0abc;
            end
        end else if (cap_w && cap_rg == 5'd0) begin
            busy_left = post_m;
        end else if (!cap_w && cap_rg == 5'd1) begin
            mg_rsp_rdata = tgt_data;
        end
        xidx++;
        mg_rsp_valid = 1'b1;
    endtask

    // downstream responder
    initial begin
        mg_ready = 1'b0; mg_rsp_valid = 1'b0; mg_rsp_err = 1'b0; mg_rsp_rdata = '0;
        stall_left = 0;
        forever begin
            @(negedge clk);
            mg_rsp_valid = 1'b0;
            mg_rsp_err   = 1'b0;
            if (mg_ready) begin
                mg_ready = 1'b0;
                respond();
            end else if (mg_valid) begin
                if (stall_left > 0) begin
                    stall_left--;
                end else begin
                    cap_w = mg_write; cap_phy = mg_phy; cap_rg = mg_reg; cap_wd = mg_wdata;
                    mg_ready   = 1'b1;
                    stall_left = stall_n;
                end
            end
        end
    end

    // response monitor
    initial begin
        resp_t r;
        forever begin
            @(negedge clk);
            if (rsp_valid) begin
                if (rq.size() == 0) begin
                    chk(1'b0, "R12", "unexpected response", 32'(rsp_result), 32'hff);
                end else begin
                    r = rq.pop_front();
                    chk(rsp_result == r.res, r.tag, "result code", 32'(rsp_result), 32'(r.res));
                    chk(rsp_rdata == r.rd, r.tag, "read data", 32'(rsp_rdata), 32'(r.rd));
                end
            end
        end
    end

    task automatic add_x(input bit w, input logic [4:0] phy, input logic [4:0] rg,
                         input logic [15:0] wd);
        if (e_dead) return;
        xq.push_back('{w: w, phy: phy, rg: rg, wd: wd, tag: e_tag});
        if (e_idx == e_errat) begin
            e_dead = 1'b1;
            e_res  = 2'd1;
        end
        e_idx++;
    endtask

    task automatic add_poll(input int busy, input logic [4:0] sw);
        for (int i = 0; i < 16; i++) begin
            if (e_dead) return;
            add_x(1'b0, sw, 5'd0, 16'h0);
            if (e_dead) return;
            if (i >= busy) return;
        end
        e_dead = 1'b1;
        e_res  = 2'd2;
    endtask

    task automatic run_req(input bit wr, input logic [4:0] dev, input logic [4:0] rg,
                           input logic [15:0] wd, input int pre, input int post,
                           input int errat, input int stall, input logic [15:0] data,
                           input string tag);
        logic [15:0] rd;
        logic [15:0] cmdw;
        logic [4:0]  sw;
        while (!req_ready) @(negedge clk);
        sw = cfg_sw_addr;
        busy_left = pre; post_m = post; err_at = errat; xidx = 0;
        tgt_data = data; stall_n = stall; stall_left = stall;
        cur_direct = (sw == 5'd0);
        e_idx = 0; e_dead = 1'b0; e_res = 2'd0; e_errat = errat; e_tag = tag;
        rd = 16'h0;
        cmdw = 16'h9000 | (wr ? 16'h0400 : 16'h0800) | (16'(dev) << 5) | 16'(rg);
        if (sw == 5'd0) begin
            add_x(wr, dev, rg, wd);
            if (!e_dead && !wr) rd = data;
        end else if (!cfg_multi_ok) begin
            e_res = 2'd3;
        end else if (!wr) begin
            add_poll(pre, sw);
            add_x(1'b1, sw, 5'd0, cmdw);
            add_poll(post, sw);
            add_x(1'b0, sw, 5'd1, 16'h0);
            if (!e_dead) rd = data;
        end else begin
            add_poll(pre, sw);
            add_x(1'b1, sw, 5'd1, wd);
            add_x(1'b1, sw, 5'd0, cmdw);
            add_poll(post, sw);
        end
        rq.push_back('{res: e_res, rd: rd, tag: tag});
        req_valid = 1'b1; req_write = wr; req_dev = dev; req_reg = rg; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R10", "ready after accept", 32'(req_ready), 32'h0);
        while (rq.size() != 0) @(negedge clk);
        @(negedge clk);
        chk(req_ready == 1'b1, "R10", "ready after response", 32'(req_ready), 32'h1);
        chk(xq.size() == 0, tag, "missing transactions", 32'(xq.size()), 32'h0);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    // stimulus
    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
        req_dev = '0; req_reg = '0; req_wdata = '0;
        cfg_sw_addr = 5'd0; cfg_multi_ok = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R10", "reset ready", 32'(req_ready), 32'h1);
        chk(mg_valid == 1'b0, "R11", "reset mg_valid", 32'(mg_valid), 32'h0);
        chk(rsp_valid == 1'b0, "R12", "reset rsp_valid", 32'(rsp_valid), 32'h0);

        // direct mode
        run_req(1'b0, 5'd7, 5'd3, 16'h0, 0, 0, -1, 0, 16'h1234, "R1");
        run_req(1'b1, 5'd18, 5'd31, 16'hbeef, 0, 0, -1, 0, 16'h0, "R1");
        cfg_multi_ok = 1'b1;
        run_req(1'b0, 5'd2, 5'd9, 16'h0, 4, 0, -1, 0, 16'h7777, "R1");

        // indirect mode
        cfg_sw_addr = 5'h10;
        run_req(1'b0, 5'd5, 5'd1, 16'h0, 0, 0, -1, 0, 16'h4321, "R6");
        run_req(1'b0, 5'd31, 5'd30, 16'h0, 1, 2, -1, 0, 16'h5a5a, "R8");
        run_req(1'b1, 5'd3, 5'd17, 16'hcafe, 2, 3, -1, 0, 16'h0, "R7");
        run_req(1'b1, 5'd0, 5'd0, 16'h00ff, 0, 0, -1, 0, 16'h0, "R12");
        run_req(1'b0, 5'd9, 5'd4, 16'h0, 3, 0, -1, 0, 16'h0f0f, "R4");
        cfg_sw_addr = 5'h06;
        run_req(1'b0, 5'd12, 5'd6, 16'h0, 1, 1, -1, 3, 16'h9999, "R11");
        run_req(1'b0, 5'd4, 5'd2, 16'h0, 0, 0, -1, 0, 16'h2468, "R2");

        // poll bound
        run_req(1'b0, 5'd1, 5'd1, 16'h0, 15, 15, -1, 0, 16'hface, "R5");
        run_req(1'b0, 5'd1, 5'd2, 16'h0, 16, 0, -1, 0, 16'hface, "R5");
        run_req(1'b1, 5'd1, 5'd3, 16'h1111, 0, 16, -1, 0, 16'h0, "R5");
        run_req(1'b1, 5'd1, 5'd4, 16'h2222, 15, 0, -1, 0, 16'h0, "R5");

        // bus errors
        run_req(1'b0, 5'd8, 5'd8, 16'h0, 1, 0, 2, 0, 16'h3333, "R9");
        run_req(1'b1, 5'd8, 5'd9, 16'h4444, 0, 0, 0, 0, 16'h0, "R9");
        run_req(1'b1, 5'd8, 5'd10, 16'h5555, 0, 2, 4, 0, 16'h0, "R9");
        run_req(1'b0, 5'd8, 5'd11, 16'h0, 0, 0, 3, 0, 16'h6666, "R9");
        cfg_sw_addr = 5'd0;
        run_req(1'b0, 5'd8, 5'd12, 16'h0, 0, 0, 0, 0, 16'h7777, "R9");

        // bad configuration
        cfg_sw_addr = 5'h04; cfg_multi_ok = 1'b0;
        run_req(1'b0, 5'd3, 5'd3, 16'h0, 0, 0, -1, 0, 16'h1357, "R3");
        run_req(1'b1, 5'd3, 5'd3, 16'habcd, 0, 0, -1, 0, 16'h0, "R3");
        cfg_sw_addr = 5'd0;
        run_req(1'b0, 5'd6, 5'd6, 16'h0, 0, 0, -1, 0, 16'h0246, "R1");

        repeat (4) @(negedge clk);
        chk(mg_valid == 1'b0, "R11", "idle mg_valid", 32'(mg_valid), 32'h0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule